// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block runs one read or one write at a time on an external, acknowledge-terminated bus. A requester raises `start` for one clock together with the address, direction, size, transfer type and write data. The block then steps the bus through a fixed sequence of half-clock phases and pulses `done` when the transfer is over. For a read, the captured data is valid on `rdata` in the same clock as `done`.

Each clock cycle holds two phases. The rising-edge phase carries address-side outputs: address, direction, size, type, transfer start and transfer in progress. The falling-edge phase carries the strobes: address strobe, chip select, byte enables and output enable. A registered state machine sets the rising-edge outputs. A separate stage clocked on the falling edge places the strobes.

The state machine has four states, and each state spans one rising phase and the falling phase after it:
- `ST_IDLE`: no cycle is running.
- `ST_S01`: the address phase S0 followed by the strobe phase S1.
- `ST_S23`: S2 followed by the acknowledge-wait phase S3. The machine repeats this state for every wait state.
- `ST_S45`: the closing phases S4 and S5.

The transitions are:
- `ST_IDLE` to `ST_S01` when `start` is sampled high.
- `ST_S01` to `ST_S45` when `ack_n` is low. This is the fast termination path.
- `ST_S01` to `ST_S23` when `ack_n` is high.
- `ST_S23` to itself while `ack_n` stays high.
- `ST_S23` to `ST_S45` when `ack_n` is low.
- `ST_S45` back to `ST_IDLE` unconditionally.

Top module: `bus_seq`

## Requirements
- R1: While reset is asserted, the outputs hold these values: `tip_n`, `ts_n`, `as_n`, `cs_n` and `oe_n` are 1, `be_n` is all ones, `d_oe` is 0 and `done` is 0.
- R2: At the rising edge that samples `start` in idle, the following outputs take effect: `bus_addr`, `bus_rw` (1 = read, 0 = write), `bus_size` and `bus_type` take the request values, and `ts_n` and `tip_n` go low.
- R3: At the following falling edge, `as_n` and `cs_n` go low. `oe_n` goes low only for a read.
- R4: In the same falling-edge phase as R3, `be_n[k]` (lane k is data bits 8k+7:8k) goes low for the selected lanes and stays high for the others. The lanes selected depend on `bus_size`:
  - 01 (byte): lane `addr[1:0]`.
  - 10 (half word): lanes `{addr[1],0}` and `{addr[1],1}`.
  - 00 or 11 (word): all four lanes.
- R5: If `ack_n` is low at the rising edge that ends S1, the cycle skips the wait phases. `done` is then high after the very next rising edge.
- R6: `ts_n` is low for exactly one clock. It rises at the edge that ends S1.
- R7: For a write, `d_oe` is 1 and `d_out` equals the write data from the edge that ends S1 until the cycle ends. For a read, `d_oe` stays 0.
- R8: Each rising edge in S3 that samples `ack_n` high adds one whole clock, and the strobes stay asserted during those clocks.
- R9: A read captures `d_in` at the rising edge where `ack_n` is sampled low. The captured value appears on `rdata` while `done` is high.
- R10: The strobes rise at the falling edge after the acknowledge edge. At the next rising edge, `tip_n` rises, `d_oe` drops and `done` is high for exactly one clock.
- R11: `start` is ignored while a cycle is active, including the clock in which `done` rises. The bus address is unchanged, and no new cycle begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges used |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a transfer (sampled in idle) |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_addr | input | AW | Request address |
| req_size | input | 2 | Size code (00 word, 01 byte, 10 half, 11 word) |
| req_type | input | TTW | Transfer type attribute |
| req_wdata | input | DW | Write data |
| rdata | output | DW | Captured read data |
| done | output | 1 | One-clock completion pulse |
| bus_addr | output | AW | Bus address |
| bus_rw | output | 1 | Bus direction, high for read |
| bus_size | output | 2 | Bus size code |
| bus_type | output | TTW | Bus transfer type |
| ts_n | output | 1 | Transfer start, active low |
| tip_n | output | 1 | Transfer in progress, active low |
| as_n | output | 1 | Address strobe, active low |
| cs_n | output | 1 | Chip select, active low |
| be_n | output | DW/8 | Byte enables, active low |
| oe_n | output | 1 | Output enable, active low |
| d_out | output | DW | Data bus drive value |
| d_oe | output | 1 | Data bus drive enable (0 = high impedance) |
| d_in | input | DW | Data bus sampled value |
| ack_n | input | 1 | Transfer acknowledge, active low |

## Verification
The hardest situation to reach is a request that arrives while a cycle is still closing. In the clock where `done` rises, the state machine has already left the wait phases but has not yet returned to idle. The stimulus task can hold `start` high with a changed address for the whole cycle, through that final edge, on both fast-terminated and wait-state cycles. The bench then checks that neither the bus address nor `tip_n` reacts. The random mix also covers zero to four wait states with every size code and lane offset, so that the acknowledge arrives at each possible edge.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_S01  = 2'd1,
        ST_S23  = 2'd2,
        ST_S45  = 2'd3
    } seq_state_t;

    localparam logic [1:0] SZ_WORD = 2'b00;
    localparam logic [1:0] SZ_BYTE = 2'b01;
    localparam logic [1:0] SZ_HALF = 2'b10;
    localparam logic [1:0] SZ_LINE = 2'b11;
endpackage

// File: rtl/bus_lane_dec.sv
module bus_lane_dec
    import bus_seq_pkg::*;
#(
    parameter int LANES = 4,
    localparam int LB = $clog2(LANES)
) (
    input  logic [LB-1:0]    addr_lo,
    input  logic [1:0]       size,
    output logic [LANES-1:0] lanes_on
);
    int nbytes;
    int base;

    always_comb begin
        unique case (size)
            SZ_BYTE: nbytes = 1;
            SZ_HALF: nbytes = 2;
            default: nbytes = LANES;
        endcase
        base = int'(addr_lo) & ~(nbytes - 1);
        for (int k = 0; k < LANES; k++) begin
            lanes_on[k] = (k >= base) && (k < base + nbytes);
        end
    end
endmodule

// File: rtl/bus_seq_negstage.sv
module bus_seq_negstage #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_en,
    input  logic             rd,
    input  logic [LANES-1:0] lanes_on,
    output logic             as_n,
    output logic             cs_n,
    output logic             oe_n,
    output logic [LANES-1:0] be_n
);
    // Falling-edge register stage: strobes move only in the low phase.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            as_n <= 1'b1;
            cs_n <= 1'b1;
            oe_n <= 1'b1;
            be_n <= '1;
        end else begin
            as_n <= !strobe_en;
            cs_n <= !strobe_en;
            oe_n <= !(strobe_en && rd);
            be_n <= strobe_en ? ~lanes_on : '1;
        end
    end
endmodule

// File: rtl/bus_seq.sv
module bus_seq
    import bus_seq_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int TTW = 2,
    localparam int LANES = DW / 8,
    localparam int LB = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             req_rd,
    input  logic [AW-1:0]    req_addr,
    input  logic [1:0]       req_size,
    input  logic [TTW-1:0]   req_type,
    input  logic [DW-1:0]    req_wdata,
    output logic [DW-1:0]    rdata,
    output logic             done,
    output logic [AW-1:0]    bus_addr,
    output logic             bus_rw,
    output logic [1:0]       bus_size,
    output logic [TTW-1:0]   bus_type,
    output logic             ts_n,
    output logic             tip_n,
    output logic             as_n,
    output logic             cs_n,
    output logic [LANES-1:0] be_n,
    output logic             oe_n,
    output logic [DW-1:0]    d_out,
    output logic             d_oe,
    input  logic [DW-1:0]    d_in,
    input  logic             ack_n
);
    seq_state_t state, nxt;
    logic [DW-1:0]    wbuf;
    logic [LANES-1:0] lanes_on;
    logic             strobe_en;
    logic             acked;

    assign acked = (state == ST_S01 || state == ST_S23) && !ack_n;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = start ? ST_S01 : ST_IDLE;
            ST_S01:  nxt = !ack_n ? ST_S45 : ST_S23;
            ST_S23:  nxt = !ack_n ? ST_S45 : ST_S23;
            ST_S45:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Rising-edge outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tip_n    <= 1'b1;
            ts_n     <= 1'b1;
            done     <= 1'b0;
            d_oe     <= 1'b0;
            bus_addr <= '0;
            bus_rw   <= 1'b1;
            bus_size <= SZ_WORD;
            bus_type <= '0;
            wbuf     <= '0;
            rdata    <= '0;
        end else begin
            tip_n <= (nxt == ST_IDLE);
            ts_n  <= (nxt != ST_S01);
            done  <= (state == ST_S45);
            d_oe  <= !bus_rw && (nxt == ST_S23 || nxt == ST_S45);
            if (state == ST_IDLE && start) begin
                bus_addr <= req_addr;
                bus_rw   <= req_rd;
                bus_size <= req_size;
                bus_type <= req_type;
                wbuf     <= req_wdata;
            end
            if (acked && bus_rw) rdata <= d_in;
        end
    end

    assign d_out     = wbuf;
    assign strobe_en = (state == ST_S01) || (state == ST_S23);

    bus_lane_dec #(.LANES(LANES)) u_lanes (
        .addr_lo  (bus_addr[LB-1:0]),
        .size     (bus_size),
        .lanes_on (lanes_on)
    );

    bus_seq_negstage #(.LANES(LANES)) u_neg (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_en (strobe_en),
        .rd        (bus_rw),
        .lanes_on  (lanes_on),
        .as_n      (as_n),
        .cs_n      (cs_n),
        .oe_n      (oe_n),
        .be_n      (be_n)
    );
endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic tip_n,
    input logic ts_n,
    input logic as_n,
    input logic oe_n,
    input logic bus_rw,
    input logic d_oe,
    input logic done
);
    // R10
    strobe_in_tip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n |-> !tip_n);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $rose(tip_n));
    // R6
    ts_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_n |=> ts_n);
    // R7
    write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_oe |-> !bus_rw);
    // R3
    oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> bus_rw);
endmodule

bind bus_seq bus_seq_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tip_n  (tip_n),
    .ts_n   (ts_n),
    .as_n   (as_n),
    .oe_n   (oe_n),
    .bus_rw (bus_rw),
    .d_oe   (d_oe),
    .done   (done)
);

// File: tb/sim_bus_seq.sv
module sim_bus_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        req_rd = 1'b1;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [1:0]  req_type = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rdata;
    logic        done;
    logic [31:0] bus_addr;
    logic        bus_rw;
    logic [1:0]  bus_size;
    logic [1:0]  bus_type;
    logic        ts_n, tip_n, as_n, cs_n, oe_n, d_oe;
    logic [3:0]  be_n;
    logic [31:0] d_out;
    logic [31:0] d_in = '0;
    logic        ack_n = 1'b1;

    int nchk = 0;
    int nfail = 0;
    bit ended = 0;

    always #10 clk = ~clk;  // 50 MHz

    bus_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .req_rd(req_rd),
        .req_addr(req_addr), .req_size(req_size), .req_type(req_type),
        .req_wdata(req_wdata), .rdata(rdata), .done(done),
        .bus_addr(bus_addr), .bus_rw(bus_rw), .bus_size(bus_size),
        .bus_type(bus_type), .ts_n(ts_n), .tip_n(tip_n), .as_n(as_n),
        .cs_n(cs_n), .be_n(be_n), .oe_n(oe_n), .d_out(d_out),
        .d_oe(d_oe), .d_in(d_in), .ack_n(ack_n)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [31:0] a);
        case (sz)
            2'b01:   return ~(4'b0001 << a[1:0]);
            2'b10:   return a[1] ? 4'b0011 : 4'b1100;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    // One full transfer; waits = clocks with ack_n high in S3; hog keeps start high throughout
    task automatic run(input bit rd, input logic [31:0] a, input logic [1:0] sz,
                       input logic [1:0] tt, input logic [31:0] wd, input int waits,
                       input logic [31:0] rv, input bit hog);
        logic [31:0] prev_rdata;
        prev_rdata = rdata;
        @(posedge clk); #2;
        start = 1; req_rd = rd; req_addr = a; req_size = sz; req_type = tt; req_wdata = wd;
        @(posedge clk);  // E0
        #2;
        if (hog) begin req_addr = ~a; req_rd = ~rd; req_size = ~sz; end
        else start = 0;
        if (waits == 0) begin ack_n = 0; d_in = rv; end
        #3;
        chk(bus_addr == a, "R2 addr", bus_addr, a);
        chk(bus_rw == rd, "R2 rw", bus_rw, rd);
        chk(bus_size == sz && bus_type == tt, "R2 size/type", {bus_size, bus_type}, {sz, tt});
        chk(!ts_n && !tip_n, "R2 ts/tip", {ts_n, tip_n}, 0);
        chk(as_n, "R3 as before fall", as_n, 1);
        #10;
        chk(!as_n && !cs_n, "R3 as/cs", {as_n, cs_n}, 0);
        chk(oe_n == !rd, "R3 oe", oe_n, !rd);
        chk(be_n == exp_be(sz, a), "R4 be", be_n, exp_be(sz, a));
        for (int w = 0; w < waits; w++) begin
            @(posedge clk); #2;
            if (w == waits - 1) begin ack_n = 0; d_in = rv; end
            #3;
            chk(ts_n, "R6 ts negated", ts_n, 1);
            chk(!as_n && !cs_n && !tip_n, "R8 wait strobes", {as_n, cs_n, tip_n}, 0);
            chk(done == 0, "R8 no done in wait", done, 0);
            chk(d_oe == !rd, "R7 drive", d_oe, !rd);
            if (!rd) chk(d_out == wd, "R7 data", d_out, wd);
            chk(bus_addr == a, "R11 addr held", bus_addr, a);
        end
        @(posedge clk);  // acknowledge edge
        #2; ack_n = 1; d_in = $urandom;
        #3;
        chk(ts_n, "R6 ts negated", ts_n, 1);
        chk(!as_n && !tip_n, "R10 S4 strobes", {as_n, tip_n}, 0);
        chk(done == 0, "R5 done not yet", done, 0);
        chk(d_oe == !rd, "R7 drive S4", d_oe, !rd);
        if (!rd) chk(d_out == wd, "R7 data S4", d_out, wd);
        chk(bus_addr == a, "R11 addr held", bus_addr, a);
        #10;
        chk(as_n && cs_n && oe_n && be_n == 4'hF, "R10 S5 released",
            {as_n, cs_n, oe_n, be_n}, 7'h7F);
        chk(!tip_n, "R10 tip in S5", tip_n, 0);
        @(posedge clk);
        #2; start = 0;
        #3;
        chk(done, "R5 done", done, 1);
        chk(tip_n && !d_oe, "R10 end", {tip_n, d_oe}, 2'b10);
        chk(rdata == (rd ? rv : prev_rdata), "R9 rdata", rdata, rd ? rv : prev_rdata);
        @(posedge clk); #5;
        chk(!done, "R10 done one clock", done, 0);
        chk(tip_n && ts_n, "R11 no restart", {tip_n, ts_n}, 2'b11);
    endtask

    initial begin
        #(200000 * 20);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        repeat (3) @(posedge clk);
        #5;
        // R1
        chk(tip_n && ts_n && as_n && cs_n && oe_n && be_n == 4'hF && !d_oe && !done,
            "R1 reset", {tip_n, ts_n, as_n, cs_n, oe_n, be_n, d_oe, done}, 11'h7FC);
        @(posedge clk); #2; rst_n = 1;
        // directed corners
        run(1, 32'h1000_0003, 2'b01, 2'd1, 32'h0, 0, 32'hA5A5_1234, 0);  // R5 fast read, byte lane 3
        run(0, 32'h2000_0002, 2'b10, 2'd2, 32'hDEAD_BEEF, 0, 32'h0, 0);  // R5 fast write, upper half
        run(0, 32'h3000_0000, 2'b10, 2'd0, 32'h0BAD_F00D, 3, 32'h0, 0);  // R8 waits
        run(1, 32'h4000_0001, 2'b00, 2'd3, 32'h0, 2, 32'h1357_9BDF, 1);  // R11 hog
        run(1, 32'h5000_0002, 2'b11, 2'd0, 32'h0, 0, 32'h2468_ACE0, 1);  // R11 hog fast
        for (int i = 0; i < 40; i++) begin
            run($urandom_range(1, 0), $urandom, 2'($urandom_range(3, 0)),
                2'($urandom_range(3, 0)), $urandom, $urandom_range(4, 0),
                $urandom, ($urandom_range(4, 0) == 0));
        end
        finish_run();
    end
endmodule